// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block is a purely combinational shifter for the second-operand path of a processor datapath. It takes a data word, a three-bit shift kind, a shift count and the current carry flag. It returns the shifted word and a shifter carry that logical operations can write back as their carry flag. It supports these shift kinds:

- logical shifts in both directions;
- an arithmetic left shift, identical to the logical left shift;
- a sign-filling arithmetic right shift;
- a rotate right;
- a single-step rotate right that passes through the carry flag.

Every shift kind produces a defined carry-out, including counts of zero and counts of the full word width. Only one logarithmic right-shifting core exists. Left shifts reuse it by mirroring the word on its way in and on its way out. The word width is a parameter and must be a power of two. The count port is one bit wider than log2 of the width, so a count equal to the width can be expressed.

Top module: `operand_shifter`

## Requirements
- R1: Kind code 0 (logical left) and kind code 2 (arithmetic left) both give `operand << n` with zeros entering at bit 0. Their results and carries are identical for every input.
- R2: Kind code 1 (logical right) gives `operand >> n` with zeros entering at the top bit.
- R3: Kind code 3 (arithmetic right) fills the vacated upper bits with copies of bit WIDTH-1 of the operand.
- R4: Kind code 4 (rotate right) moves every bit leaving bit 0 back into bit WIDTH-1. The count is taken modulo WIDTH, and the number of set bits is preserved.
- R5: Kind code 5 (rotate through carry) ignores the count. It returns `{carry_i, operand[WIDTH-1:1]}`, and carry_o is operand bit 0.
- R6: For kind codes 0 to 4 with a count of 0, result_o equals operand_i and carry_o equals carry_i.
- R7: For kind codes 0 to 3 with a count n from 1 to WIDTH, carry_o is the last bit shifted out. This is operand bit WIDTH-n for left shifts and operand bit n-1 for right shifts.
- R8: At a count of exactly WIDTH:
  - a logical left shift gives zero with carry equal to bit 0;
  - a logical right shift gives zero with carry equal to bit WIDTH-1;
  - an arithmetic right shift gives every bit and the carry equal to the sign bit.
- R9: For a rotate with a nonzero count, carry_o equals result bit WIDTH-1. A count of WIDTH returns the operand unchanged with carry equal to bit WIDTH-1.
- R10: For counts above WIDTH:
  - logical shifts give zero with carry 0;
  - an arithmetic right shift gives all bits and the carry equal to the sign bit.
- R11: Kind codes 6 and 7 pass the operand through unchanged and return carry_i as carry_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | WIDTH | Word to be shifted |
| kind_i | input | 3 | Shift kind code (0 LSL, 1 LSR, 2 ASL, 3 ASR, 4 ROR, 5 rotate through carry, 6/7 pass) |
| amount_i | input | $clog2(WIDTH)+1 | Shift count |
| carry_i | input | 1 | Current carry flag |
| result_o | output | WIDTH | Shifted word |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The block holds no state, so a wrong stage select or a wrong fill value shows up at result_o in the same evaluation as the input that exercises it. A fault in the carry index selection only shows for particular counts. A fault in the mirroring path only shows for left shifts. For these reasons the bench sweeps every kind code against every count, from 0 up to the largest value the count port can hold. Each combination is applied with both carry polarities and with a set of operand patterns chosen so that each bit position is both set and clear somewhere.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

   typedef enum logic [2:0] {
      SHK_LSL  = 3'd0,
      SHK_LSR  = 3'd1,
      SHK_ASL  = 3'd2,
      SHK_ASR  = 3'd3,
      SHK_ROR  = 3'd4,
      SHK_RRXC = 3'd5
   } shift_kind_e;

   function automatic bit is_pow2(input int value);
      return (value > 1) && ((value & (value - 1)) == 0);
   endfunction

endpackage

// File: rtl/opsh_bitrev.sv
module opsh_bitrev #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] data_i,
   output logic [WIDTH-1:0] data_o
);

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign data_o[b] = data_i[WIDTH-1-b];
   end

endmodule

// File: rtl/opsh_right_core.sv
module opsh_right_core #(
   parameter int WIDTH = 32,
   parameter int AMT_W = $clog2(WIDTH) + 1
) (
   input  logic [WIDTH-1:0] data_i,
   input  logic [AMT_W-1:0] amount_i,
   input  logic             fill_i,
   input  logic             rotate_i,
   output logic [WIDTH-1:0] data_o,
   output logic             carry_o
);

   localparam int LOG_W = $clog2(WIDTH);

   logic [WIDTH-1:0] stage [0:AMT_W];
   assign stage[0] = data_i;

   for (genvar k = 0; k < AMT_W; k++) begin : g_stage
      localparam int STEP = 1 << k;
      logic [WIDTH-1:0] moved;
      if (STEP < WIDTH) begin : g_part
         assign moved = rotate_i ? {stage[k][STEP-1:0], stage[k][WIDTH-1:STEP]}
                                 : {{STEP{fill_i}}, stage[k][WIDTH-1:STEP]};
      end else begin : g_full
         assign moved = rotate_i ? stage[k] : {WIDTH{fill_i}};
      end
      assign stage[k+1] = amount_i[k] ? moved : stage[k];
   end

   assign data_o = stage[AMT_W];

   logic [AMT_W-1:0] amt_less1;
   logic [LOG_W-1:0] out_idx;
   logic             beyond;

   assign amt_less1 = amount_i - AMT_W'(1);
   assign out_idx   = amt_less1[LOG_W-1:0];
   assign beyond    = amount_i > AMT_W'(WIDTH);

   always_comb begin
      if (rotate_i)    carry_o = data_o[WIDTH-1];
      else if (beyond) carry_o = fill_i;
      else             carry_o = data_i[out_idx];
   end

endmodule

// File: rtl/operand_shifter.sv
module operand_shifter #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0]         operand_i,
   input  logic [2:0]               kind_i,
   input  logic [$clog2(WIDTH):0]   amount_i,
   input  logic                     carry_i,
   output logic [WIDTH-1:0]         result_o,
   output logic                     carry_o
);
   import opsh_pkg::*;

   localparam int AMT_W = $clog2(WIDTH) + 1;

   if (!is_pow2(WIDTH)) begin : g_bad_width
      $error("operand_shifter: WIDTH must be a power of two above 1");
   end

   logic             go_left;
   logic             fill_bit;
   logic             do_rotate;
   logic [WIDTH-1:0] mirrored_in;
   logic [WIDTH-1:0] core_in;
   logic [WIDTH-1:0] core_out;
   logic [WIDTH-1:0] mirrored_out;
   logic             core_carry;

   assign go_left   = (kind_i == SHK_LSL) || (kind_i == SHK_ASL);
   assign fill_bit  = (kind_i == SHK_ASR) && operand_i[WIDTH-1];
   assign do_rotate = (kind_i == SHK_ROR);

   opsh_bitrev #(.WIDTH(WIDTH)) u_rev_in (
      .data_i (operand_i),
      .data_o (mirrored_in)
   );

   assign core_in = go_left ? mirrored_in : operand_i;

   opsh_right_core #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_core (
      .data_i   (core_in),
      .amount_i (amount_i),
      .fill_i   (fill_bit),
      .rotate_i (do_rotate),
      .data_o   (core_out),
      .carry_o  (core_carry)
   );

   opsh_bitrev #(.WIDTH(WIDTH)) u_rev_out (
      .data_i (core_out),
      .data_o (mirrored_out)
   );

   always_comb begin
      result_o = operand_i;
      carry_o  = carry_i;
      case (kind_i)
         SHK_LSL, SHK_LSR, SHK_ASL, SHK_ASR, SHK_ROR: begin
            if (amount_i != '0) begin
               result_o = go_left ? mirrored_out : core_out;
               carry_o  = core_carry;
            end
         end
         SHK_RRXC: begin
            result_o = {carry_i, operand_i[WIDTH-1:1]};
            carry_o  = operand_i[0];
         end
         default: begin
            result_o = operand_i;
            carry_o  = carry_i;
         end
      endcase
   end

   always_comb begin
      if (!$isunknown({operand_i, kind_i, amount_i, carry_i})) begin
         // R6
         zero_amt_pass_chk: assert (!(kind_i <= 3'd4 && amount_i == '0) ||
                                    (result_o == operand_i && carry_o == carry_i));
         // R5
         rrx_step_chk: assert (kind_i != 3'd5 ||
                               (result_o[WIDTH-2:0] == operand_i[WIDTH-1:1] &&
                                result_o[WIDTH-1] == carry_i && carry_o == operand_i[0]));
         // R3
         asr_sign_keep_chk: assert (kind_i != 3'd3 || result_o[WIDTH-1] == operand_i[WIDTH-1]);
         // R4
         ror_ones_chk: assert (kind_i != 3'd4 || $countones(result_o) == $countones(operand_i));
         // R1
         logical_ones_chk: assert (kind_i > 3'd2 || $countones(result_o) <= $countones(operand_i));
         // R11
         spare_pass_chk: assert (kind_i < 3'd6 ||
                                 (result_o == operand_i && carry_o == carry_i));
      end
   end

endmodule

// File: tb/sim_operand_shifter.sv
module sim_operand_shifter;

   localparam int W = 32;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [W-1:0]  operand;
   logic [2:0]    kind;
   logic [AW-1:0] amount;
   logic          cin;
   logic [W-1:0]  result;
   logic          cout;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   operand_shifter #(.WIDTH(W)) u0 (
      .operand_i (operand),
      .kind_i    (kind),
      .amount_i  (amount),
      .carry_i   (cin),
      .result_o  (result),
      .carry_o   (cout)
   );

   function automatic logic [W:0] model(input logic [W-1:0] x, input logic [2:0] k,
                                        input int n, input logic c);
      logic [2*W-1:0]        wide;
      logic signed [2*W-1:0] sw;
      logic [W-1:0]          r;
      case (k)
         3'd0, 3'd2: begin
            wide = {{W{1'b0}}, x} << n;
            return (n == 0) ? {c, x} : {wide[W], wide[W-1:0]};
         end
         3'd1: begin
            wide = {x, {W{1'b0}}} >> n;
            return (n == 0) ? {c, x} : {wide[W-1], wide[2*W-1:W]};
         end
         3'd3: begin
            sw = $signed({x, {W{1'b0}}}) >>> n;
            return (n == 0) ? {c, x} : {sw[W-1], sw[2*W-1:W]};
         end
         3'd4: begin
            wide = {x, x} >> (n % W);
            r = wide[W-1:0];
            return (n == 0) ? {c, x} : {r[W-1], r};
         end
         3'd5: return {x[0], c, x[W-1:1]};
         default: return {c, x};
      endcase
   endfunction

   function automatic string tag(input logic [2:0] k, input int n);
      if (k >= 3'd6) return "R11";
      if (k == 3'd5) return "R5";
      if (n == 0) return "R6";
      if (k == 3'd4) return (n % W == 0) ? "R9" : "R4";
      if (n > W) return "R10";
      if (n == W) return "R8";
      if (k == 3'd3) return "R3";
      if (k == 3'd1) return "R2";
      return "R1";
   endfunction

   task automatic check(input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s kind=%0d amt=%0d op=%h cin=%b: actual %h expected %h",
                  req, what, kind, amount, operand, cin, act, exp);
      end
   endtask

   logic [W-1:0] pats [0:11];

   initial begin
      logic [W:0] exp;
      logic [W-1:0] lsl_r;
      logic lsl_c;
      pats[0]  = 32'h0000_0000; pats[1]  = 32'hFFFF_FFFF;
      pats[2]  = 32'h8000_0000; pats[3]  = 32'h0000_0001;
      pats[4]  = 32'hAAAA_AAAA; pats[5]  = 32'h5555_5555;
      pats[6]  = 32'h8765_4321; pats[7]  = 32'h1234_5678;
      pats[8]  = 32'h7FFF_FFFF; pats[9]  = 32'hF0F0_0F0F;
      pats[10] = 32'hC000_0003; pats[11] = 32'h0001_8000;
      operand = '0; kind = '0; amount = '0; cin = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R6: quiet inputs give a zero word and carry 0
      check("R6", "reset-state result", result, '0);
      check("R6", "reset-state carry", {31'b0, cout}, '0);
      for (int p = 0; p < 12; p++) begin
         for (int k = 0; k < 8; k++) begin
            for (int n = 0; n < 64; n++) begin
               for (int c = 0; c < 2; c++) begin
                  @(posedge clk);
                  operand = pats[p]; kind = 3'(k); amount = 6'(n); cin = c[0];
                  @(negedge clk);
                  exp = model(pats[p], 3'(k), n, c[0]);
                  check(tag(3'(k), n), "result", result, exp[W-1:0]);
                  check(tag(3'(k), n), "carry", {31'b0, cout}, {31'b0, exp[W]});
               end
            end
         end
      end
      // R1: ASL matches LSL port for port
      for (int n = 0; n < 64; n++) begin
         @(posedge clk);
         operand = 32'h8765_4321; kind = 3'd0; amount = 6'(n); cin = 1'b1;
         @(negedge clk);
         lsl_r = result; lsl_c = cout;
         @(posedge clk);
         kind = 3'd2;
         @(negedge clk);
         check("R1", "asl vs lsl result", result, lsl_r);
         check("R1", "asl vs lsl carry", {31'b0, cout}, {31'b0, lsl_c});
      end
      // R8: explicit full-width corners
      @(posedge clk); operand = 32'h8000_0001; kind = 3'd0; amount = 6'd32; cin = 1'b0;
      @(negedge clk);
      check("R8", "lsl32 result", result, '0);
      check("R8", "lsl32 carry bit0", {31'b0, cout}, 32'd1);
      @(posedge clk); operand = 32'h8000_0000; kind = 3'd1;
      @(negedge clk);
      check("R8", "lsr32 carry bit31", {31'b0, cout}, 32'd1);
      // R7: last bit out
      @(posedge clk); operand = 32'h0000_0010; kind = 3'd1; amount = 6'd5; cin = 1'b0;
      @(negedge clk);
      check("R7", "lsr5 carry", {31'b0, cout}, 32'd1);
      @(posedge clk); operand = 32'h0800_0000; kind = 3'd0; amount = 6'd5;
      @(negedge clk);
      check("R7", "lsl5 carry", {31'b0, cout}, 32'd1);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 190000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule